// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is the serial programming front end of a frequency synthesizer. A host shifts 24-bit words in over a serial clock and data pair, most significant bit first. A rising edge on a load strobe then copies the word into one of eight 24-bit configuration registers. The three least significant bits of that same word pick the register, and they are stored along with the rest of the word.

The serial clock, serial data and load strobe are asynchronous to the system clock. Two-flop synchronizers bring them into the system clock domain, and edges are detected there. The system clock must therefore run at least four times faster than the serial clock. A write to any register raises that register's write strobe for one cycle. A write to one of the three frequency registers (0, 1 or 2) also raises a one-cycle calibration-start pulse, so that the synthesizer recalibrates after every frequency change.

Top module: `serial_cfg_bank`

## Requirements
- R1: After reset the registers hold reg0=0x0001C0, reg1=0x003001, reg2=0x001802, reg3=0x10000B, reg4=0x0AA7E4, reg5=0x0000E5, reg6=0x1E2106 and reg7=0x000007. No write strobe and no calibration pulse is asserted.
- R2: Serial data is captured on each rising serial clock edge and enters at the least significant end. Each earlier bit moves one place toward the most significant end. Only the last 24 bits shifted before the load edge are used.
- R3: A load-strobe rising edge writes the shifted word only into register N, where N is bits [2:0] of the word. Every other register keeps its value.
- R4: The stored value is the whole 24-bit word, including the three select bits.
- R5: Each write raises the written register's bit in `wr_stb_o` for exactly one system clock cycle, in the same cycle that the new value first appears on `reg_o`. No more than one strobe bit is ever high at a time.
- R6: `cal_start_o` pulses for one cycle, together with the strobe, exactly when the written register is 0, 1 or 2. Writes to registers 3 to 7 do not raise it.
- R7: Shifting serial bits without a load edge changes no register and raises no strobe.
- R8: A load edge does not clear the shift register. A second load edge with no new bits writes the same word again, and its strobe fires again.
- R9: Holding the load strobe high produces only one write. A new write needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first |
| sload_i | input | 1 | Load strobe; the rising edge commits the word |
| reg_o | output | 192 | Eight registers packed; register k is at [24k+23:24k] |
| wr_stb_o | output | 8 | One-cycle write strobe, one bit per register |
| cal_start_o | output | 1 | One-cycle calibration start on writes to registers 0 to 2 |

## Verification
The bench writes all eight registers. After each write it checks that only the addressed register changed and that the strobe and calibration counts rose by the right amount. A decode that ignored the low bits, or that did not gate calibration on the register index, would fail these checks. It shifts a word of more than 24 bits to catch a shift register that is cleared on load or fed from the wrong end. It reloads with no new bits to catch a shifter that is cleared, and it holds the load strobe high to catch level-triggered writes, which would produce repeated strobes. A burst of serial bits with no load edge exposes any write that leaks past the load edge.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_WORD_W   = 24;
  localparam int CFG_ADDR_W   = 3;
  localparam int CFG_CAL_REGS = 3;
  localparam int CFG_SYNC_N   = 2;

  function automatic logic [CFG_WORD_W-1:0] reset_word(input int idx);
    case (idx)
      0:       return 24'h0001C0;
      1:       return 24'h003001;
      2:       return 24'h001802;
      3:       return 24'h10000B;
      4:       return 24'h0AA7E4;
      5:       return 24'h0000E5;
      6:       return 24'h1E2106;
      7:       return 24'h000007;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic lvl;
  logic lvl_q;

  cfg_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign rise_o = lvl & ~lvl_q;
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  // never cleared by load: a repeated load reuses the word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/cfg_reg_slot.sv
module cfg_reg_slot #(
  parameter int              WORD_W = 24,
  parameter logic [WORD_W-1:0] INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= INIT;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
  import cfg_pkg::*;
#(
  parameter int WORD_W   = CFG_WORD_W,
  parameter int ADDR_W   = CFG_ADDR_W,
  parameter int CAL_REGS = CFG_CAL_REGS,
  parameter int SYNC_N   = CFG_SYNC_N,
  localparam int N_REGS  = 1 << ADDR_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sdata_i,
  input  logic                     sload_i,
  output logic [N_REGS*WORD_W-1:0] reg_o,
  output logic [N_REGS-1:0]        wr_stb_o,
  output logic                     cal_start_o
);
  localparam logic [ADDR_W:0] CAL_LIM = (ADDR_W+1)'(CAL_REGS);

  logic              sclk_rise;
  logic              load_rise;
  logic              sdata_s;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] sel;
  logic [N_REGS-1:0] hit;
  logic [N_REGS-1:0] stb_q;
  logic              cal_q;

  cfg_edge_sync #(.STAGES(SYNC_N)) u_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .rise_o(sclk_rise)
  );

  cfg_edge_sync #(.STAGES(SYNC_N)) u_load (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sload_i), .rise_o(load_rise)
  );

  // same depth as the clock path so the bit lines up with its edge
  cfg_sync #(.STAGES(SYNC_N)) u_data (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdata_i), .q_o(sdata_s)
  );

  cfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sclk_rise),
    .bit_i  (sdata_s),
    .word_o (word)
  );

  assign sel = word[ADDR_W-1:0];

  always_comb begin
    hit = '0;
    if (load_rise) hit[sel] = 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < N_REGS; g++) begin : g_slot
      cfg_reg_slot #(
        .WORD_W(WORD_W),
        .INIT  (WORD_W'(reset_word(g)))
      ) u_slot (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .we_i  (hit[g]),
        .d_i   (word),
        .q_o   (reg_o[g*WORD_W +: WORD_W])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= '0;
      cal_q <= 1'b0;
    end else begin
      stb_q <= hit;
      cal_q <= load_rise && ({1'b0, sel} < CAL_LIM);
    end
  end

  assign wr_stb_o    = stb_q;
  assign cal_start_o = cal_q;
endmodule

// File: rtl/serial_cfg_bank_chk.sv
module serial_cfg_bank_chk #(
  parameter int N_REGS   = 8,
  parameter int WORD_W   = 24,
  parameter int CAL_REGS = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_REGS*WORD_W-1:0] reg_i,
  input logic [N_REGS-1:0]        wr_stb_i,
  input logic                     cal_start_i
);
  localparam logic [N_REGS-1:0] CAL_MASK = N_REGS'((1 << CAL_REGS) - 1);

  assert_strobe_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_stb_i));

  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_stb_i) |=> (wr_stb_i == '0));

  assert_cal_has_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_i |-> (|(wr_stb_i & CAL_MASK)));

  assert_freq_write_cals_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(wr_stb_i & CAL_MASK)) |-> cal_start_i);

  genvar g;
  generate
    for (g = 0; g < N_REGS; g++) begin : g_hold
      assert_hold_unless_written_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_i[g*WORD_W +: WORD_W] != $past(reg_i[g*WORD_W +: WORD_W])) |-> wr_stb_i[g]);
    end
  endgenerate
endmodule

bind serial_cfg_bank serial_cfg_bank_chk #(
  .N_REGS  (N_REGS),
  .WORD_W  (WORD_W),
  .CAL_REGS(CAL_REGS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_i      (reg_o),
  .wr_stb_i   (wr_stb_o),
  .cal_start_i(cal_start_o)
);

// File: tb/serial_cfg_bank_test.sv
module serial_cfg_bank_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0;
  logic         sdata = 1'b0;
  logic         sload = 1'b0;
  logic [191:0] regs;
  logic [7:0]   stb;
  logic         cal;

  int n_cmp = 0;
  int n_bad = 0;
  int stb_cnt [8];
  int cal_cnt = 0;
  logic [23:0] exp_r [8];
  bit done = 0;

  always #10 clk = ~clk;

  serial_cfg_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .sload_i(sload), .reg_o(regs), .wr_stb_o(stb), .cal_start_o(cal)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 8; i++) if (stb[i]) stb_cnt[i]++;
      if (cal) cal_cnt++;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++)
      check(req, $sformatf("reg%0d", i), 32'(regs[i*24 +: 24]), 32'(exp_r[i]));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b0;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_word(input logic [23:0] w);
    for (int k = 23; k >= 0; k--) send_bit(w[k]);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_load(input int hold);
    @(negedge clk); sload = 1'b1;
    repeat (hold) @(negedge clk);
    sload = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // write one word and check bank, strobe and calibration (R3 R4 R5 R6)
  task automatic t_write(input logic [23:0] w);
    int idx = int'(w[2:0]);
    int s0 = stb_cnt[idx];
    int c0 = cal_cnt;
    int tot0 = 0;
    int tot1 = 0;
    for (int i = 0; i < 8; i++) tot0 += stb_cnt[i];
    send_word(w);
    pulse_load(4);
    exp_r[idx] = w;
    check_all("R3/R4");
    for (int i = 0; i < 8; i++) tot1 += stb_cnt[i];
    check("R5", "strobe count", 32'(stb_cnt[idx] - s0), 32'd1);
    check("R5", "total strobes", 32'(tot1 - tot0), 32'd1);
    check("R6", "cal pulses", 32'(cal_cnt - c0), (idx < 3) ? 32'd1 : 32'd0);
  endtask

  task automatic t_reset;
    exp_r[0] = 24'h0001C0; exp_r[1] = 24'h003001;
    exp_r[2] = 24'h001802; exp_r[3] = 24'h10000B;
    exp_r[4] = 24'h0AA7E4; exp_r[5] = 24'h0000E5;
    exp_r[6] = 24'h1E2106; exp_r[7] = 24'h000007;
    check_all("R1");
    check("R1", "strobes", 32'(stb), 32'd0);
    check("R1", "cal", 32'(cal), 32'd0);
  endtask

  task automatic t_overlong;
    int c0 = cal_cnt;
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    send_word(24'hABCDE5);
    pulse_load(4);
    exp_r[5] = 24'hABCDE5;
    check_all("R2");
    check("R2", "no cal for reg5", 32'(cal_cnt - c0), 32'd0);
  endtask

  task automatic t_no_load;
    int tot0 = 0;
    int tot1 = 0;
    for (int i = 0; i < 8; i++) tot0 += stb_cnt[i];
    send_word(24'h123450);
    send_word(24'h6789A1);
    for (int i = 0; i < 8; i++) tot1 += stb_cnt[i];
    check_all("R7");
    check("R7", "strobes without load", 32'(tot1 - tot0), 32'd0);
  endtask

  task automatic t_reload;
    int s0 = stb_cnt[1];
    int c0 = cal_cnt;
    pulse_load(4);
    exp_r[1] = 24'h6789A1;
    check_all("R8");
    check("R8", "reg1 strobe", 32'(stb_cnt[1] - s0), 32'd1);
    check("R8", "cal on reload", 32'(cal_cnt - c0), 32'd1);
  endtask

  task automatic t_held_load;
    int s0 = stb_cnt[6];
    send_word(24'h55AA36);
    pulse_load(60);
    exp_r[6] = 24'h55AA36;
    check_all("R9");
    check("R9", "single strobe", 32'(stb_cnt[6] - s0), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) stb_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    for (int i = 0; i < 8; i++)
      t_write(((24'h9E3700 + 24'(i) * 24'h010101) & ~24'h7) | 24'(i));
    t_overlong();
    t_no_load();
    t_reload();
    t_held_load();
    t_write(24'h000002);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule